// File: doc/BRIEF.md
# Power-Management Event and SCI Controller

This block holds the power-management event registers of a chipset: an event status register, an event enable register, a control register and a free-running power-management timer. Software reaches them through a 64-byte I/O window. The window base comes from a configuration word, and an enable input gates the decode. The bus side is a plain single-cycle read/write strobe with a 16-bit address, 16-bit write data and 32-bit read data.

From the enabled status bits and one general-purpose hotplug event, the block drives a level-sensitive system control interrupt (SCI). A command byte on the legacy power-management port switches SCI mode on or off. When the system-management interrupt is enabled, each such command also produces a one-cycle system-management interrupt (SMI) pulse. A power-button request input records a button event in the status register. The timer advances on an external tick enable, and each flip of its most significant bit raises the timer status event.

Top module: `pm_evt_ctl`

## Requirements
- R1: An access decodes only while `win_en_i` is high and `bus_addr_i[15:6]` equals `win_cfg_i[15:6]`; the low six bits of `win_cfg_i` are ignored. Outside the window, reads return zero and writes change nothing.
- R2: Window offsets map as follows: 0x00 is status, 0x02 is enable, 0x04 is control and 0x08 is the timer. Reads at any other offset, odd offsets included, return zero, and writes there change no register.
- R3: Status bits sit at position 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC). All other bits read zero. Writing a one clears a bit and writing a zero leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R4: The enable register holds only bits 0, 5, 8 and 10. Writing 0xFFFF reads back as 0x0521.
- R5: A bus write to control updates bits 15:1. Bit 0 (SCI enable) is not changed by any bus write.
- R6: An APM command of 0xF1 sets control bit 0 and 0xF0 clears it. Every other command value leaves control bit 0 unchanged.
- R7: Each APM command write gives a one-cycle `smi_o` pulse in the following cycle when `smi_en_i` is high, and no pulse when it is low.
- R8: A cycle with `pwrbtn_req_i` high sets status bit 8.
- R9: The timer is a TMR_W-bit up-counter (default 24) that advances once per clock cycle with `tick_i` high. It reads at offset 0x08 zero-extended to 32 bits and starts from zero after reset.
- R10: Each change of the timer's most significant bit, in either direction, sets status bit 0.
- R11: `sci_o` is high one cycle after control bit 0 is set together with either a nonzero (status AND enable) or both `gpe_hp_sts_i` and `gpe_hp_en_i` high.
- R12: While control bit 0 is clear, `sci_o` stays low whatever the status, enable and hotplug inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_cfg_i | input | 16 | Configuration word giving the window base (low 6 bits ignored) |
| win_en_i | input | 1 | Window decode enable |
| bus_addr_i | input | 16 | I/O byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| tick_i | input | 1 | Timer advance enable |
| pwrbtn_req_i | input | 1 | Power-button request |
| gpe_hp_sts_i | input | 1 | Hotplug general-purpose event status |
| gpe_hp_en_i | input | 1 | Hotplug general-purpose event enable |
| apm_wr_i | input | 1 | APM command write strobe |
| apm_cmd_i | input | 8 | APM command byte |
| smi_en_i | input | 1 | SMI generation enable |
| sci_o | output | 1 | System control interrupt level |
| smi_o | output | 1 | System management interrupt pulse |

## Verification
The bench counts the timer to one below its MSB flip and then one tick further. A design that compares against a terminal count, or that raises the event on wrap only, sets timer status at the wrong tick. It checks that a bus write to control keeps the APM-owned SCI enable bit, that an unrelated APM code leaves that bit alone, and that a set enable bit no longer drives SCI once SCI enable drops. A design that lets software clear the bit, or that does not gate SCI, fails there. It also writes one window above the base and at unmapped and odd offsets, where a loose address compare would corrupt the enable register.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int DATA_W      = 16;
  localparam int RDATA_W     = 32;

  localparam int TMR_BIT     = 0;
  localparam int GLK_BIT     = 5;
  localparam int PWRBTN_BIT  = 8;
  localparam int RTC_BIT     = 10;
  localparam int SCI_EN_BIT  = 0;

  localparam logic [DATA_W-1:0] EVT_MASK =
    (DATA_W'(1) << TMR_BIT) | (DATA_W'(1) << GLK_BIT) |
    (DATA_W'(1) << PWRBTN_BIT) | (DATA_W'(1) << RTC_BIT);

  localparam int OFS_STS = 'h00;
  localparam int OFS_EN  = 'h02;
  localparam int OFS_CTL = 'h04;
  localparam int OFS_TMR = 'h08;

  localparam logic [7:0] APM_SCI_ON  = 8'hF1;
  localparam logic [7:0] APM_SCI_OFF = 8'hF0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STS,
    SEL_EN,
    SEL_CTL,
    SEL_TMR
  } rd_sel_e;
endpackage

// File: rtl/pm_io_decode.sv
module pm_io_decode
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] cfg_i,
  input  logic              win_en_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              wr_sts_o,
  output logic              wr_en_o,
  output logic              wr_ctl_o,
  output rd_sel_e           sel_o
);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << WIN_BITS) - ADDR_W'(1));

  logic                hit;
  logic [WIN_BITS-1:0] ofs;

  assign hit = win_en_i && ((addr_i & BASE_MASK) == (cfg_i & BASE_MASK));
  assign ofs = addr_i[WIN_BITS-1:0];

  always_comb begin
    wr_sts_o = 1'b0;
    wr_en_o  = 1'b0;
    wr_ctl_o = 1'b0;
    sel_o    = SEL_NONE;
    if (hit) begin
      if (ofs == WIN_BITS'(OFS_STS)) begin
        wr_sts_o = wr_i;
        if (rd_i) sel_o = SEL_STS;
      end else if (ofs == WIN_BITS'(OFS_EN)) begin
        wr_en_o = wr_i;
        if (rd_i) sel_o = SEL_EN;
      end else if (ofs == WIN_BITS'(OFS_CTL)) begin
        wr_ctl_o = wr_i;
        if (rd_i) sel_o = SEL_CTL;
      end else if (ofs == WIN_BITS'(OFS_TMR)) begin
        if (rd_i) sel_o = SEL_TMR;
      end
    end
  end
endmodule

// File: rtl/pm_tmr.sv
module pm_tmr #(
  parameter int TMR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             msb_flip_o
);
  logic [TMR_W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt    = cnt_q + TMR_W'(1);
  assign msb_flip_o = tick_i && (cnt_nxt[TMR_W-1] != cnt_q[TMR_W-1]);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt;
  end

  // R9
  tmr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_sts_i,
  input  logic              wr_en_i,
  input  logic              wr_ctl_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tmr_flip_i,
  input  logic              pwrbtn_req_i,
  input  logic              apm_wr_i,
  input  logic [7:0]        apm_cmd_i,
  input  logic              gpe_hp_sts_i,
  input  logic              gpe_hp_en_i,
  output logic [DATA_W-1:0] sts_o,
  output logic [DATA_W-1:0] en_o,
  output logic [DATA_W-1:0] ctl_o,
  output logic              sci_o
);
  logic [DATA_W-1:0] sts_q, sts_d, en_q, ctl_q, set_v, clr_v;
  logic              sci_q, sci_d;

  always_comb begin
    set_v             = '0;
    set_v[TMR_BIT]    = tmr_flip_i;
    set_v[PWRBTN_BIT] = pwrbtn_req_i;
    clr_v             = wr_sts_i ? (wdata_i & EVT_MASK) : '0;
    sts_d             = ((sts_q & ~clr_v) | set_v) & EVT_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= sts_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (wr_en_i) en_q <= wdata_i & EVT_MASK;
  end

  // bit 0 is owned by APM commands, upper bits by the bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      if (wr_ctl_i) ctl_q[DATA_W-1:1] <= wdata_i[DATA_W-1:1];
      if (apm_wr_i) begin
        if (apm_cmd_i == APM_SCI_ON)       ctl_q[SCI_EN_BIT] <= 1'b1;
        else if (apm_cmd_i == APM_SCI_OFF) ctl_q[SCI_EN_BIT] <= 1'b0;
      end
    end
  end

  assign sci_d = ctl_q[SCI_EN_BIT] &&
                 ((|(sts_q & en_q)) || (gpe_hp_sts_i && gpe_hp_en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sci_q <= 1'b0;
    else         sci_q <= sci_d;
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign ctl_o = ctl_q;
  assign sci_o = sci_q;

  // R3
  sts_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sts_i && wdata_i[PWRBTN_BIT] && !pwrbtn_req_i |=> !sts_q[PWRBTN_BIT]);
  // R8
  pwrbtn_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrbtn_req_i |=> sts_q[PWRBTN_BIT]);
  // R10
  tmr_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_flip_i |=> sts_q[TMR_BIT]);
  // R6
  apm_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apm_wr_i && (apm_cmd_i == APM_SCI_ON) |=> ctl_q[SCI_EN_BIT]);
  // R6
  apm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apm_wr_i && (apm_cmd_i == APM_SCI_OFF) |=> !ctl_q[SCI_EN_BIT]);
  // R5
  ctl_bus_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl_i && !apm_wr_i |=> $stable(ctl_q[SCI_EN_BIT]));
  // R12
  sci_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_q[SCI_EN_BIT] |=> !sci_q);
endmodule

// File: rtl/pm_evt_ctl.sv
module pm_evt_ctl
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 6,
  parameter int TMR_W    = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  win_cfg_i,
  input  logic               win_en_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [RDATA_W-1:0] bus_rdata_o,
  input  logic               tick_i,
  input  logic               pwrbtn_req_i,
  input  logic               gpe_hp_sts_i,
  input  logic               gpe_hp_en_i,
  input  logic               apm_wr_i,
  input  logic [7:0]         apm_cmd_i,
  input  logic               smi_en_i,
  output logic               sci_o,
  output logic               smi_o
);
  logic              wr_sts, wr_en, wr_ctl, tmr_flip, smi_q;
  rd_sel_e           sel;
  logic [DATA_W-1:0] sts, en, ctl;
  logic [TMR_W-1:0]  tmr_cnt;

  pm_io_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
    .addr_i   (bus_addr_i),
    .cfg_i    (win_cfg_i),
    .win_en_i (win_en_i),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .wr_sts_o (wr_sts),
    .wr_en_o  (wr_en),
    .wr_ctl_o (wr_ctl),
    .sel_o    (sel)
  );

  pm_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .cnt_o      (tmr_cnt),
    .msb_flip_o (tmr_flip)
  );

  pm_evt_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_sts_i     (wr_sts),
    .wr_en_i      (wr_en),
    .wr_ctl_i     (wr_ctl),
    .wdata_i      (bus_wdata_i),
    .tmr_flip_i   (tmr_flip),
    .pwrbtn_req_i (pwrbtn_req_i),
    .apm_wr_i     (apm_wr_i),
    .apm_cmd_i    (apm_cmd_i),
    .gpe_hp_sts_i (gpe_hp_sts_i),
    .gpe_hp_en_i  (gpe_hp_en_i),
    .sts_o        (sts),
    .en_o         (en),
    .ctl_o        (ctl),
    .sci_o        (sci_o)
  );

  always_comb begin
    case (sel)
      SEL_STS: bus_rdata_o = RDATA_W'(sts);
      SEL_EN:  bus_rdata_o = RDATA_W'(en);
      SEL_CTL: bus_rdata_o = RDATA_W'(ctl);
      SEL_TMR: bus_rdata_o = RDATA_W'(tmr_cnt);
      default: bus_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_q <= 1'b0;
    else         smi_q <= apm_wr_i && smi_en_i;
  end
  assign smi_o = smi_q;

  // R7
  smi_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apm_wr_i && smi_en_i |=> smi_o);
  // R7
  smi_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apm_wr_i |=> !smi_o);
  // R1
  win_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_en_i |-> bus_rdata_o == '0);
endmodule

// File: tb/pm_evt_ctl_tb.sv
module pm_evt_ctl_tb;
  localparam int TMR_W = 10;
  localparam logic [15:0] CFG  = 16'hB03F;
  localparam logic [15:0] BASE = 16'hB000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        win_en = 1'b1;
  logic [15:0] addr = '0, wdata = '0;
  logic        wr = 1'b0, rd = 1'b0, tick = 1'b0, pwrbtn = 1'b0;
  logic        gsts = 1'b0, gen = 1'b0, apm_wr = 1'b0, smi_en = 1'b0;
  logic [7:0]  apm_cmd = '0;
  logic [31:0] rdata;
  logic        sci, smi;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2.5ns clk = ~clk;

  pm_evt_ctl #(.TMR_W(TMR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .win_cfg_i(CFG), .win_en_i(win_en),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .tick_i(tick), .pwrbtn_req_i(pwrbtn),
    .gpe_hp_sts_i(gsts), .gpe_hp_en_i(gen), .apm_wr_i(apm_wr),
    .apm_cmd_i(apm_cmd), .smi_en_i(smi_en), .sci_o(sci), .smi_o(smi)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1ns d = rdata;
    rd = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [15:0] a, logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic apm(logic [7:0] c);
    @(negedge clk); apm_cmd = c; apm_wr = 1'b1;
    @(negedge clk); apm_wr = 1'b0;
  endtask

  task automatic press;
    @(negedge clk); pwrbtn = 1'b1;
    @(negedge clk); pwrbtn = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic sci_chk(string req, logic exp);
    repeat (2) @(negedge clk);
    #1ns chk(req, 32'(sci), 32'(exp));
  endtask

  task automatic t_reset;
    rd_chk("R2 reset sts", BASE + 16'h0, 0);
    rd_chk("R2 reset en", BASE + 16'h2, 0);
    rd_chk("R2 reset ctl", BASE + 16'h4, 0);
    rd_chk("R9 reset tmr", BASE + 16'h8, 0);
    chk("R12 reset sci", 32'(sci), 0);
    chk("R7 reset smi", 32'(smi), 0);
  endtask

  task automatic t_timer;
    ticks(5);
    rd_chk("R9 tmr count", BASE + 16'h8, 5);
    ticks(506);
    rd_chk("R10 no event before msb", BASE + 16'h0, 0);
    ticks(1);
    rd_chk("R10 event on msb flip", BASE + 16'h0, 32'h0001);
    rd_chk("R9 tmr zero-extended", BASE + 16'h8, 32'd512);
    bus_wr(BASE + 16'h0, 16'h0001);
    rd_chk("R3 w1c timer bit", BASE + 16'h0, 0);
  endtask

  task automatic t_enable;
    bus_wr(BASE + 16'h2, 16'hFFFF);
    rd_chk("R4 enable mask", BASE + 16'h2, 32'h0521);
    bus_wr(BASE + 16'h2, 16'h0000);
    rd_chk("R4 enable clear", BASE + 16'h2, 0);
  endtask

  task automatic t_window;
    win_en = 1'b0;
    bus_wr(BASE + 16'h2, 16'h0100);
    rd_chk("R1 read while disabled", BASE + 16'h2, 0);
    win_en = 1'b1;
    rd_chk("R1 write while disabled ignored", BASE + 16'h2, 0);
    bus_wr(BASE + 16'h42, 16'h0100);
    rd_chk("R1 read outside window", BASE + 16'h42, 0);
    rd_chk("R1 write outside window ignored", BASE + 16'h2, 0);
  endtask

  task automatic t_undef;
    bus_wr(BASE + 16'h6, 16'hFFFF);
    bus_wr(BASE + 16'h3, 16'hFFFF);
    bus_wr(BASE + 16'hC, 16'hFFFF);
    rd_chk("R2 undef write sts", BASE + 16'h0, 0);
    rd_chk("R2 undef write en", BASE + 16'h2, 0);
    rd_chk("R2 undef write ctl", BASE + 16'h4, 0);
    rd_chk("R2 undef read 06", BASE + 16'h6, 0);
    rd_chk("R2 undef read 03", BASE + 16'h3, 0);
  endtask

  task automatic t_apm_ctl;
    apm(8'h55);
    rd_chk("R6 other code no effect", BASE + 16'h4, 0);
    apm(8'hF1);
    rd_chk("R6 F1 sets sci_en", BASE + 16'h4, 32'h0001);
    bus_wr(BASE + 16'h4, 16'h2400);
    rd_chk("R5 bus write keeps bit0", BASE + 16'h4, 32'h2401);
    apm(8'hF0);
    rd_chk("R6 F0 clears sci_en", BASE + 16'h4, 32'h2400);
    bus_wr(BASE + 16'h4, 16'h0001);
    rd_chk("R5 bus cannot set bit0", BASE + 16'h4, 0);
  endtask

  task automatic t_smi;
    smi_en = 1'b1;
    @(negedge clk); apm_cmd = 8'h12; apm_wr = 1'b1;
    @(negedge clk); apm_wr = 1'b0;
    #1ns chk("R7 smi pulse", 32'(smi), 1);
    @(negedge clk);
    #1ns chk("R7 smi one cycle", 32'(smi), 0);
    smi_en = 1'b0;
    @(negedge clk); apm_wr = 1'b1;
    @(negedge clk); apm_wr = 1'b0;
    #1ns chk("R7 no smi when disabled", 32'(smi), 0);
  endtask

  task automatic t_pwrbtn;
    press();
    rd_chk("R8 power button status", BASE + 16'h0, 32'h0100);
    bus_wr(BASE + 16'h0, 16'h0100);
    rd_chk("R3 w1c power button", BASE + 16'h0, 0);
  endtask

  task automatic t_sci;
    apm(8'hF1);
    bus_wr(BASE + 16'h2, 16'h0100);
    sci_chk("R11 idle low", 0);
    press();
    sci_chk("R11 enabled status raises", 1);
    bus_wr(BASE + 16'h0, 16'h0100);
    sci_chk("R11 drops after clear", 0);
    press();
    sci_chk("R11 raised again", 1);
    apm(8'hF0);
    sci_chk("R12 gated by sci_en", 0);
    apm(8'hF1);
    sci_chk("R11 regated on", 1);
    bus_wr(BASE + 16'h2, 16'h0000);
    sci_chk("R11 masked by enable", 0);
    bus_wr(BASE + 16'h0, 16'h0100);
    @(negedge clk); gsts = 1'b1; gen = 1'b1;
    sci_chk("R11 gpe hotplug raises", 1);
    @(negedge clk); gen = 1'b0;
    sci_chk("R11 gpe enable low", 0);
    @(negedge clk); gen = 1'b1;
    apm(8'hF0);
    sci_chk("R12 gpe gated by sci_en", 0);
    @(negedge clk); gsts = 1'b0; gen = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_enable();
    t_window();
    t_undef();
    t_apm_ctl();
    t_smi();
    t_pwrbtn();
    t_sci();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule